// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the master side of an 8-bit full-duplex serial link. When the host writes a byte to the data buffer while the engine is idle, a transfer begins at once. The byte is shifted out on the serial data output, most significant bit first. At the same time, one bit per bit time is captured from the serial data input. When the last bit is in, the received byte is placed in the buffer and the completion flag is raised.

Four static controls set the waveform:

- the idle level of the serial clock;
- whether output data is valid before the first clock edge or launched by it;
- whether the input is sampled mid-bit or at the end of the bit;
- the bit rate, which is one of three fixed system-clock divisions or half the rate of an external timer tick.

A receive-only mode turns the data output off and keeps transfers running back to back. Every captured byte lands in the buffer, so the block can serve as a line activity monitor.

Buffer-full, overflow and write-collision flags report how the host is keeping up. Every transfer is 2·W half-periods long, numbered 0 to 2·W−1.

Top module: `spi_master_engine`

## Requirements
- R1: A cycle with `wr_en` high while `busy` is low starts a transfer. `busy` is high from the next cycle, and the transfer lasts exactly 2·W half-periods.
- R2: `sdo` carries `wr_data` MSB first. Bit W−1−i is held through half-periods 2i and 2i+1.
- R3: Whenever `busy` is low, `sck` equals `cpol`. This includes reset and the cycle after completion.
- R4: During a transfer, `sck` is `cpol` XOR (half-period index bit 0) XOR NOT `early_data`. With `early_data`=1 the first edge comes after half-period 0. With `early_data`=0 the first edge comes at the start of the transfer.
- R5: With `smp_late`=0, `sdi` is sampled at the end of half-period 2i (mid-bit). With `smp_late`=1, it is sampled at the end of half-period 2i+1 (end of bit).
- R6: `rate_sel` sets the length of each half-period. Code 0 gives DIV_A/2 cycles, code 1 gives DIV_B/2 cycles and code 2 gives DIV_C/2 cycles (2, 8 and 32 with the defaults). Code 3 gives one half-period per `tmr_tick` pulse. In codes 0 to 2, `tmr_tick` is ignored.
- R7: On the clock edge that ends the last half-period, `busy` drops (unless receive-only), the received byte is loaded and `done_irq` is set.
- R8: `buf_full` is set when a byte is loaded and cleared by a `rd_en` cycle. `rd_data` always shows the buffer.
- R9: If a byte completes while `buf_full` is set, `overflow` is set and the buffer keeps its old contents.
- R10: A `wr_en` while `busy` is high is ignored: the output stream is unchanged. It also sets `wr_coll`.
- R11: With `rx_only`=1, `sdo_oe` is low, and on completion the next transfer starts on the same edge without a host write.
- R12: A `flag_clr` cycle clears `done_irq`, `overflow` and `wr_coll`, but leaves `buf_full` alone. A flag event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Idle level of sck |
| early_data | input | 1 | 1: data valid before first edge; 0: data launched by first edge |
| smp_late | input | 1 | 0: sample mid-bit; 1: sample at end of bit |
| rate_sel | input | 2 | Bit-rate select (see R6) |
| rx_only | input | 1 | Receive-only continuous mode |
| tmr_tick | input | 1 | External timer pulse, one per half-period in rate code 3 |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | W | Byte to transmit |
| rd_en | input | 1 | Buffer read strobe |
| rd_data | output | W | Buffer contents |
| flag_clr | input | 1 | Clears done_irq, overflow, wr_coll |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | Completion flag |
| buf_full | output | 1 | Unread byte in buffer |
| overflow | output | 1 | Byte completed while buffer full |
| wr_coll | output | 1 | Write attempted during transfer |

## Verification
Counting from the write edge E0, with H cycles per half-period:

- `busy` and `sck` show half-period k from E0+k·H onward.
- `sdo` changes only at odd-to-even half boundaries.
- The captured byte, `done_irq` and `buf_full` appear from E0+2·W·H.

The bench counts edges from E0 itself. It drives `sdi` (and `tmr_tick`) on falling edges for the half-period that the next rising edge closes, and it compares `sck`, `sdo` and `busy` on each falling edge. It feeds different bits in the two halves of each bit time, so the byte it reads back shows which sample point was used. Flag and buffer checks are taken on the falling edge just after the completion edge or just after the one-cycle host strobe.

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
  parameter int W     = 8,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpol,
  input  logic         early_data,
  input  logic         smp_late,
  input  logic [1:0]   rate_sel,
  input  logic         rx_only,
  input  logic         tmr_tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  input  logic         flag_clr,
  output logic         sck,
  output logic         sdo,
  output logic         sdo_oe,
  input  logic         sdi,
  output logic         busy,
  output logic         done_irq,
  output logic         buf_full,
  output logic         overflow,
  output logic         wr_coll
);
  localparam int HW = $clog2(2 * W);
  localparam int CW = $clog2(DIV_C / 2);

  logic [HW-1:0] half_idx;
  logic [CW-1:0] cnt, half_max;
  logic [W-1:0]  tx_sr, rx_sr, buf_q;

  always_comb begin
    case (rate_sel)
      2'd0:    half_max = CW'(DIV_A / 2 - 1);
      2'd1:    half_max = CW'(DIV_B / 2 - 1);
      default: half_max = CW'(DIV_C / 2 - 1);
    endcase
  end

  wire          start    = wr_en && !busy;
  wire          half_end = busy && ((rate_sel == 2'd3) ? tmr_tick : (cnt == half_max));
  wire          last     = half_end && (half_idx == HW'(2 * W - 1));
  wire          take     = half_end && (half_idx[0] == smp_late);
  wire [W-1:0]  rx_next  = {rx_sr[W-2:0], sdi};
  wire [W-1:0]  rx_final = smp_late ? rx_next : rx_sr;

  assign sck     = busy ? (cpol ^ half_idx[0] ^ ~early_data) : cpol;
  assign sdo     = tx_sr[W-1];
  assign sdo_oe  = ~rx_only;
  assign rd_data = buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      half_idx <= '0;
      cnt      <= '0;
      tx_sr    <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      half_idx <= '0;
      cnt      <= '0;
      tx_sr    <= wr_data;
    end else if (half_end) begin
      cnt      <= '0;
      half_idx <= half_idx + 1'b1;
      if (half_idx[0]) tx_sr <= {tx_sr[W-2:0], 1'b0};
      if (last) busy <= rx_only;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sr <= '0;
    else if (take) rx_sr <= rx_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
      done_irq <= 1'b0;
      overflow <= 1'b0;
      wr_coll  <= 1'b0;
    end else begin
      if (last && !buf_full) buf_q <= rx_final;

      if (last) buf_full <= 1'b1;
      else if (rd_en) buf_full <= 1'b0;

      if (last) done_irq <= 1'b1;
      else if (flag_clr) done_irq <= 1'b0;

      if (last && buf_full) overflow <= 1'b1;
      else if (flag_clr) overflow <= 1'b0;

      if (wr_en && busy) wr_coll <= 1'b1;
      else if (flag_clr) wr_coll <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_master_engine_chk.sv
module spi_master_engine_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cpol,
  input logic         rx_only,
  input logic         wr_en,
  input logic         rd_en,
  input logic [W-1:0] rd_data,
  input logic         sck,
  input logic         busy,
  input logic         done_irq,
  input logic         buf_full,
  input logic         wr_coll
);
  // R3
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);

  // R7
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);

  // R8
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy) |=> !buf_full);

  // R9
  buf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !rd_en) |=> $stable(rd_data));

  // R10
  coll_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> wr_coll);

  // R11
  rx_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(rx_only));
endmodule

bind spi_master_engine spi_master_engine_chk #(.W(W)) u_chk (.*);

// File: tb/tb_spi_master_engine.sv
module tb_spi_master_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 1'b0, early_data = 1'b1, smp_late = 1'b0, rx_only = 1'b0, tmr_tick = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic wr_en = 1'b0, rd_en = 1'b0, flag_clr = 1'b0, sdi = 1'b0;
  logic [7:0] wr_data = 8'h00, rd_data;
  logic sck, sdo, sdo_oe, busy, done_irq, buf_full, overflow, wr_coll;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  spi_master_engine dut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .early_data(early_data), .smp_late(smp_late),
    .rate_sel(rate_sel), .rx_only(rx_only), .tmr_tick(tmr_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .flag_clr(flag_clr),
    .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi), .busy(busy),
    .done_irq(done_irq), .buf_full(buf_full), .overflow(overflow), .wr_coll(wr_coll));

  // rate, cpol, early_data, smp_late, half length, tx, sdi first half, sdi second half
  localparam logic [34:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b1, 1'b0, 6'd2,  8'hA5, 8'h3C, 8'hC3},
    {2'd0, 1'b1, 1'b0, 1'b1, 6'd2,  8'h96, 8'h0F, 8'hF0},
    {2'd1, 1'b0, 1'b0, 1'b0, 6'd8,  8'h81, 8'h5A, 8'hA5},
    {2'd2, 1'b1, 1'b1, 1'b1, 6'd32, 8'h7E, 8'h11, 8'hEE},
    {2'd3, 1'b0, 1'b1, 1'b1, 6'd3,  8'hC3, 8'h00, 8'hFF},
    {2'd3, 1'b1, 1'b0, 1'b0, 6'd5,  8'h3C, 8'h99, 8'h66}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] tx, input logic [7:0] a, input logic [7:0] b,
                     input int h, input bit wr, input int coll_at);
    int sck_bad = 0, sdo_bad = 0, busy_bad = 0;
    if (wr) begin
      wr_data = tx; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
    end
    for (int n = 0; n < 16 * h; n++) begin
      int k = n / h;
      sdi = (k % 2 == 0) ? a[7 - k / 2] : b[7 - k / 2];
      tmr_tick = (rate_sel == 2'd3) ? (n % h == h - 1) : 1'b1;
      wr_en = (n == coll_at);
      if (n == coll_at) wr_data = ~tx;
      if (sck !== (cpol ^ k[0] ^ ~early_data)) sck_bad++;
      if (sdo !== tx[7 - k / 2]) sdo_bad++;
      if (busy !== 1'b1) busy_bad++;
      @(negedge clk);
    end
    wr_en = 1'b0; tmr_tick = 1'b0;
    chk(busy_bad == 0, "R1 busy through transfer", busy_bad, 0);
    chk(sck_bad == 0, "R4 sck waveform", sck_bad, 0);
    chk(sdo_bad == 0, "R2 sdo MSB-first stream", sdo_bad, 0);
  endtask

  task automatic host(input bit rd, input bit clr);
    rd_en = rd; flag_clr = clr;
    @(negedge clk);
    rd_en = 1'b0; flag_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    chk(sck === 1'b1, "R3 reset sck idle", sck, 1);
    chk({busy, done_irq, buf_full, overflow, wr_coll} === 5'b0, "R7 reset flags",
        {busy, done_irq, buf_full, overflow, wr_coll}, 0);
    chk(rd_data === 8'h00, "R8 reset buffer", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      logic [7:0] ex;
      {rate_sel, cpol, early_data, smp_late} = VEC[i][34:30];
      ex = smp_late ? VEC[i][7:0] : VEC[i][15:8];
      @(negedge clk);
      run(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], int'(VEC[i][29:24]), 1'b1, -1);
      chk(busy === 1'b0, "R7 busy drops at completion", busy, 0);
      chk(sck === cpol, "R3 idle sck after transfer", sck, cpol);
      chk(rd_data === ex, "R5 received byte / sample point", rd_data, ex);
      chk(done_irq === 1'b1, "R7 done_irq set", done_irq, 1);
      chk(buf_full === 1'b1, "R8 buf_full set", buf_full, 1);
      host(1'b1, 1'b1);
      chk(buf_full === 1'b0 && done_irq === 1'b0, "R8 read clears full (R6 rate row)",
          {buf_full, done_irq}, 0);
    end

    // R10 write during transfer
    rate_sel = 2'd0; cpol = 1'b0; early_data = 1'b1; smp_late = 1'b0;
    run(8'h6B, 8'hD2, 8'h00, 2, 1'b1, 5);
    chk(wr_coll === 1'b1, "R10 wr_coll set", wr_coll, 1);
    chk(rd_data === 8'hD2, "R10 transfer unaffected", rd_data, 8'hD2);
    host(1'b1, 1'b0);
    chk(wr_coll === 1'b1, "R12 read leaves wr_coll", wr_coll, 1);
    host(1'b0, 1'b1);
    chk(wr_coll === 1'b0 && done_irq === 1'b0, "R12 clear flags", {wr_coll, done_irq}, 0);

    // R11 receive-only, R9 overflow
    rx_only = 1'b1;
    run(8'h55, 8'hB4, 8'hB4, 2, 1'b1, -1);
    chk(busy === 1'b1, "R11 continues without write", busy, 1);
    chk(sdo_oe === 1'b0, "R11 sdo disabled", sdo_oe, 0);
    chk(rd_data === 8'hB4 && buf_full === 1'b1, "R11 first byte loaded", rd_data, 8'hB4);
    rx_only = 1'b0;
    run(8'h00, 8'h2D, 8'h2D, 2, 1'b0, -1);
    chk(busy === 1'b0, "R11 stops when mode off", busy, 0);
    chk(overflow === 1'b1, "R9 overflow set", overflow, 1);
    chk(rd_data === 8'hB4, "R9 buffer kept", rd_data, 8'hB4);
    host(1'b1, 1'b0);
    chk(buf_full === 1'b0 && overflow === 1'b1, "R12 read leaves overflow",
        {buf_full, overflow}, 1);
    host(1'b0, 1'b1);
    chk(overflow === 1'b0, "R12 clear overflow", overflow, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule